// File: doc/BRIEF.md
# Guarded Page-Write Controller

This block sits behind a serial-bus slave front-end that has already decoded start and stop conditions, the sector select, the word address and each acknowledged data byte. It keeps a small set of control bytes, a volatile fault byte and a 256-byte memory model. For every write it decides whether the write is allowed, using a volatile write-enable latch, a hardware lock (an input pin combined with a lock-enable bit) and a two-bit block-protect field. Each received byte's acknowledge is suppressed when its target cannot be written.

Memory writes collect up to 16 bytes in a page buffer whose low address bits wrap inside the page. Nothing reaches storage until the front-end reports a stop that came on a byte boundary. A commit that changes nonvolatile state then starts a busy period of a parameterised number of clock cycles. During that period every bus request is refused. A combinational read port lets the front-end fetch any register or memory byte.

Top module: `prot_page_wr`

## Requirements
- R1: After reset the write-enable latch, the busy flag and the acknowledge-suppress output are low, and all control bytes and the fault byte (FFh) read 00h.
- R2: Register 00h holds the write-enable latch in bit 7, and its other bits read 0. Writing 80h sets the latch and 00h clears it. Such a write is accepted whatever the latch state and never starts a busy period.
- R3: While the latch is clear, writes to memory and to registers 01h–03h are refused (acknowledge suppressed, contents unchanged). The fault byte at FFh is writable with the latch clear and never starts a busy period.
- R4: Registers 01h–03h are locked when the protect pin is high and bit 7 of register 01h is set. A locked write is refused, and neither condition alone locks them. The lock leaves register 00h, FFh and unprotected memory writable.
- R5: Bits 4:3 of register 01h choose the protected memory range: 00 none, 01 C0h–FFh, 10 80h–FFh, 11 00h–FFh. A byte aimed at a protected address gets its acknowledge suppressed and is never stored.
- R6: During a memory write the low 4 address bits advance by one per byte and wrap within the 16-byte page. A later byte overwrites an earlier one at the same address, and `addrPtr` ends one past the last byte written.
- R7: A write is stored only when a clean stop (`stopClean`=1) follows at least one data byte. A stop with `stopClean`=0, or a stop with no data byte, leaves storage unchanged and starts no busy period.
- R8: A committed write that changes memory or registers 01h–03h holds `busy` high for exactly BUSY_CYCLES cycles. Meanwhile `ackSuppress` is high and starts, bytes and stops are ignored. Normal writes resume afterwards.
- R9: A register write stores only its first data byte, and further bytes in the same transfer are refused. Register addresses other than 00h–03h and FFh are refused and read as 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| protPin | input | 1 | Hardware protect pin |
| xferStart | input | 1 | One-cycle pulse: write transfer begins with sector and address |
| xferIsReg | input | 1 | Sector select for the transfer: 1 registers, 0 memory |
| xferAddr | input | 8 | Start address of the transfer |
| byteValid | input | 1 | One-cycle pulse: a full data byte was received |
| byteData | input | 8 | Data byte qualified by byteValid |
| stopStb | input | 1 | One-cycle pulse: stop condition seen |
| stopClean | input | 1 | With stopStb: stop fell on a byte boundary |
| rdIsReg | input | 1 | Read-port sector select |
| rdAddr | input | 8 | Read-port address |
| rdData | output | 8 | Combinational read data |
| ackSuppress | output | 1 | Refuse the current request or byte |
| busy | output | 1 | Nonvolatile write cycle in progress |
| addrPtr | output | 8 | Current write address pointer |

## Verification
A table of single-byte writes steps the latch, lock-enable, protect pin and block-protect field through their combinations. Each row aims at an address just inside or just outside a protected range, so the refused case and the accepted case sit next to each other. A 20-byte page write that starts two bytes before the page end shows wraparound and overwrite in one run, and where the pointer comes to rest. Torn and empty stops are separated from clean commits by the memory contents and the busy flag. A commit followed by bus traffic inside its busy window shows that the refusal lasts the whole window and ends when it should.

// File: rtl/ppw_pkg.sv
package ppw_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam int PAGE_W   = 4;
  localparam int PAGE_LEN = 1 << PAGE_W;
  localparam int MEM_DEPTH = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] RA_LATCH   = 8'h00;
  localparam logic [ADDR_W-1:0] RA_GUARD   = 8'h01;
  localparam logic [ADDR_W-1:0] RA_DELAY_A = 8'h02;
  localparam logic [ADDR_W-1:0] RA_DELAY_B = 8'h03;
  localparam logic [ADDR_W-1:0] RA_FAULT   = 8'hFF;

  localparam int GUARD_LOCK_BIT = 7;
  localparam int GUARD_BLK_HI   = 4;
  localparam int GUARD_BLK_LO   = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_WMEM, ST_WREG, ST_BUSY} state_t;

  typedef struct packed {
    logic loadBase;
    logic storeByte;
    logic commit;
  } strobe_t;

  function automatic logic memBlocked(input logic [1:0] blk, input logic [ADDR_W-1:0] a);
    case (blk)
      2'b00:   return 1'b0;
      2'b01:   return a[ADDR_W-1] & a[ADDR_W-2];
      2'b10:   return a[ADDR_W-1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic memWriteOk(input logic wel, input logic [1:0] blk,
                                      input logic [ADDR_W-1:0] a);
    return wel && !memBlocked(blk, a);
  endfunction

  function automatic logic regIsNv(input logic [ADDR_W-1:0] a);
    return (a == RA_GUARD) || (a == RA_DELAY_A) || (a == RA_DELAY_B);
  endfunction

  function automatic logic regWriteOk(input logic wel, input logic lock,
                                      input logic [ADDR_W-1:0] a);
    if (a == RA_LATCH || a == RA_FAULT) return 1'b1;
    if (regIsNv(a)) return wel && !lock;
    return 1'b0;
  endfunction
endpackage

// File: rtl/ppw_ctrl.sv
module ppw_ctrl
  import ppw_pkg::*;
#(
  parameter int BUSY_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferStart,
  input  logic              xferIsReg,
  input  logic              byteValid,
  input  logic              stopStb,
  input  logic              stopClean,
  input  logic [ADDR_W-1:0] curAddr,
  input  logic              wel,
  input  logic              hwLock,
  input  logic [1:0]        blkSel,
  input  logic              commitNv,
  output strobe_t           strb,
  output logic              ackSuppress,
  output logic              busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  state_t           state;
  logic             gotByte;
  logic [CNT_W-1:0] busyLeft;
  logic             inWrite, byteOk, cleanEnd;

  assign inWrite  = (state == ST_WMEM) || (state == ST_WREG);
  assign cleanEnd = stopStb && stopClean && gotByte;
  assign busy     = (state == ST_BUSY);

  always_comb begin
    byteOk = 1'b0;
    if (state == ST_WMEM)      byteOk = memWriteOk(wel, blkSel, curAddr);
    else if (state == ST_WREG) byteOk = !gotByte && regWriteOk(wel, hwLock, curAddr);
  end

  always_comb begin
    strb = '0;
    if (!busy) begin
      if (xferStart)                strb.loadBase = 1'b1;
      else if (inWrite && stopStb)  strb.commit   = cleanEnd;
      else if (byteValid && (state == ST_WMEM || (state == ST_WREG && !gotByte)))
        strb.storeByte = 1'b1;
    end
  end

  assign ackSuppress = busy || (inWrite && byteValid && !byteOk);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      gotByte  <= 1'b0;
      busyLeft <= '0;
    end else if (busy) begin
      if (busyLeft == '0) state <= ST_IDLE;
      else                busyLeft <= busyLeft - 1'b1;
    end else if (xferStart) begin
      state   <= xferIsReg ? ST_WREG : ST_WMEM;
      gotByte <= 1'b0;
    end else if (inWrite && stopStb) begin
      gotByte <= 1'b0;
      if (cleanEnd && commitNv) begin
        state    <= ST_BUSY;
        busyLeft <= CNT_W'(BUSY_CYCLES - 1);
      end else begin
        state <= ST_IDLE;
      end
    end else if (strb.storeByte) begin
      gotByte <= 1'b1;
    end
  end

  // R3: nothing nonvolatile can be committed with the latch clear
  a_r3_latch_clear_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && !wel) |=> !busy);
  // R5: a fully protected memory leaves no write cycle to wait for
  a_r5_full_lock_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && state == ST_WMEM && blkSel == 2'b11) |=> !busy);
  // R7: a torn stop never starts a write cycle
  a_r7_torn_stop_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    (stopStb && !stopClean && !busy) |=> !busy);
  // R8: a busy period is always entered from a commit
  a_r8_busy_from_commit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(strb.commit));
  // R8: requests arriving during the write cycle are refused
  a_r8_busy_refuses: assert property (@(posedge clk) disable iff (!rstN)
    (busy && (xferStart || byteValid)) |-> ackSuppress);
endmodule

// File: rtl/ppw_data.sv
module ppw_data
  import ppw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              protPin,
  input  logic              xferIsReg,
  input  logic [ADDR_W-1:0] xferAddr,
  input  logic [DATA_W-1:0] byteData,
  input  strobe_t           strb,
  input  logic              rdIsReg,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] curAddr,
  output logic              wel,
  output logic              hwLock,
  output logic [1:0]        blkSel,
  output logic              commitNv
);
  logic [ADDR_W-1:0]        startAddr;
  logic [PAGE_W-1:0]        ptr;
  logic                     modeReg;
  logic [DATA_W-1:0]        regByte;
  logic [DATA_W-1:0]        guardQ, delayAQ, delayBQ, faultQ;
  logic [DATA_W-1:0]        pageBuf [PAGE_LEN];
  logic [PAGE_LEN-1:0]      pageVld;
  logic [DATA_W-1:0]        mem [MEM_DEPTH];
  logic [ADDR_W-PAGE_W-1:0] base;
  logic                     regCommitOk;

  assign base        = startAddr[ADDR_W-1:PAGE_W];
  assign curAddr     = {base, ptr};
  assign hwLock      = protPin && guardQ[GUARD_LOCK_BIT];
  assign blkSel      = guardQ[GUARD_BLK_HI:GUARD_BLK_LO];
  assign regCommitOk = regWriteOk(wel, hwLock, startAddr);

  always_comb begin
    commitNv = 1'b0;
    if (modeReg) begin
      commitNv = regIsNv(startAddr) && regCommitOk;
    end else begin
      for (int i = 0; i < PAGE_LEN; i++)
        if (pageVld[i] && memWriteOk(wel, blkSel, {base, PAGE_W'(i)})) commitNv = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
      ptr       <= '0;
      modeReg   <= 1'b0;
      regByte   <= '0;
      pageVld   <= '0;
      wel       <= 1'b0;
      guardQ    <= '0;
      delayAQ   <= '0;
      delayBQ   <= '0;
      faultQ    <= '0;
    end else begin
      if (strb.loadBase) begin
        startAddr <= xferAddr;
        ptr       <= xferAddr[PAGE_W-1:0];
        modeReg   <= xferIsReg;
        pageVld   <= '0;
      end
      if (strb.storeByte) begin
        ptr <= ptr + 1'b1;
        if (modeReg) regByte <= byteData;
        else         pageVld[ptr] <= 1'b1;
      end
      if (strb.commit && modeReg) begin
        case (startAddr)
          RA_LATCH:   wel <= regByte[7];
          RA_FAULT:   faultQ <= regByte;
          RA_GUARD:   if (regCommitOk) guardQ  <= regByte;
          RA_DELAY_A: if (regCommitOk) delayAQ <= regByte;
          RA_DELAY_B: if (regCommitOk) delayBQ <= regByte;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.storeByte && !modeReg) pageBuf[ptr] <= byteData;
  end

  always_ff @(posedge clk) begin
    if (strb.commit && !modeReg) begin
      for (int i = 0; i < PAGE_LEN; i++)
        if (pageVld[i] && memWriteOk(wel, blkSel, {base, PAGE_W'(i)}))
          mem[{base, PAGE_W'(i)}] <= pageBuf[i];
    end
  end

  always_comb begin
    rdData = '0;
    if (rdIsReg) begin
      case (rdAddr)
        RA_LATCH:   rdData = {wel, 7'b0};
        RA_GUARD:   rdData = guardQ;
        RA_DELAY_A: rdData = delayAQ;
        RA_DELAY_B: rdData = delayBQ;
        RA_FAULT:   rdData = faultQ;
        default:    rdData = '0;
      endcase
    end else begin
      rdData = mem[rdAddr];
    end
  end

  // R6: storing a byte never moves the pointer out of its page
  a_r6_page_fixed: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeByte |=> (curAddr[ADDR_W-1:PAGE_W] == $past(curAddr[ADDR_W-1:PAGE_W])));
endmodule

// File: rtl/prot_page_wr.sv
module prot_page_wr
  import ppw_pkg::*;
#(
  parameter int BUSY_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              protPin,
  input  logic              xferStart,
  input  logic              xferIsReg,
  input  logic [ADDR_W-1:0] xferAddr,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              stopStb,
  input  logic              stopClean,
  input  logic              rdIsReg,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              ackSuppress,
  output logic              busy,
  output logic [ADDR_W-1:0] addrPtr
);
  strobe_t     strb;
  logic        wel, hwLock, commitNv;
  logic [1:0]  blkSel;

  ppw_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .xferStart(xferStart), .xferIsReg(xferIsReg),
    .byteValid(byteValid), .stopStb(stopStb), .stopClean(stopClean),
    .curAddr(addrPtr), .wel(wel), .hwLock(hwLock), .blkSel(blkSel),
    .commitNv(commitNv), .strb(strb), .ackSuppress(ackSuppress), .busy(busy)
  );

  ppw_data u_data (
    .clk(clk), .rstN(rstN), .protPin(protPin), .xferIsReg(xferIsReg),
    .xferAddr(xferAddr), .byteData(byteData), .strb(strb), .rdIsReg(rdIsReg),
    .rdAddr(rdAddr), .rdData(rdData), .curAddr(addrPtr), .wel(wel),
    .hwLock(hwLock), .blkSel(blkSel), .commitNv(commitNv)
  );
endmodule

// File: tb/tb_prot_page_wr.sv
module tb_prot_page_wr;
  localparam int BUSY = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       protPin = 1'b0, xferStart = 1'b0, xferIsReg = 1'b0;
  logic [7:0] xferAddr = '0, byteData = '0, rdAddr = '0;
  logic       byteValid = 1'b0, stopStb = 1'b0, stopClean = 1'b0, rdIsReg = 1'b0;
  logic [7:0] rdData, addrPtr;
  logic       ackSuppress, busy;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  prot_page_wr #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rstN(rstN), .protPin(protPin), .xferStart(xferStart),
    .xferIsReg(xferIsReg), .xferAddr(xferAddr), .byteValid(byteValid),
    .byteData(byteData), .stopStb(stopStb), .stopClean(stopClean),
    .rdIsReg(rdIsReg), .rdAddr(rdAddr), .rdData(rdData),
    .ackSuppress(ackSuppress), .busy(busy), .addrPtr(addrPtr)
  );

  // pin, isReg, addr, data, expected ackSuppress, expected readback, requirement
  typedef struct packed {
    logic       pin;
    logic       isReg;
    logic [7:0] addr;
    logic [7:0] data;
    logic       nack;
    logic [7:0] rd;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 27;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h01, 8'h55, 1'b1, 8'h00, 4'd3},  // R3 latch clear
    {1'b0, 1'b1, 8'hFF, 8'h0D, 1'b0, 8'h0D, 4'd3},  // R3 fault byte without latch
    {1'b0, 1'b1, 8'h00, 8'h80, 1'b0, 8'h80, 4'd2},  // R2 set latch
    {1'b0, 1'b0, 8'h10, 8'hAA, 1'b0, 8'hAA, 4'd5},  // R5 nothing protected
    {1'b0, 1'b1, 8'h02, 8'h0C, 1'b0, 8'h0C, 4'd4},  // R4 unlocked register
    {1'b0, 1'b0, 8'hC3, 8'h33, 1'b0, 8'h33, 4'd5},
    {1'b0, 1'b0, 8'h80, 8'h22, 1'b0, 8'h22, 4'd5},
    {1'b0, 1'b0, 8'h40, 8'h66, 1'b0, 8'h66, 4'd5},
    {1'b0, 1'b1, 8'h01, 8'h08, 1'b0, 8'h08, 4'd5},  // R5 quarter protect
    {1'b0, 1'b0, 8'hC3, 8'h11, 1'b1, 8'h33, 4'd5},
    {1'b0, 1'b0, 8'h80, 8'h23, 1'b0, 8'h23, 4'd5},
    {1'b0, 1'b1, 8'h01, 8'h90, 1'b0, 8'h90, 4'd4},  // R4 lock enable, half protect
    {1'b0, 1'b0, 8'h80, 8'h99, 1'b1, 8'h23, 4'd5},
    {1'b0, 1'b0, 8'h40, 8'h67, 1'b0, 8'h67, 4'd5},
    {1'b1, 1'b1, 8'h02, 8'h03, 1'b1, 8'h0C, 4'd4},  // R4 locked
    {1'b1, 1'b0, 8'h41, 8'h77, 1'b0, 8'h77, 4'd4},  // R4 memory still open
    {1'b1, 1'b1, 8'h00, 8'h80, 1'b0, 8'h80, 4'd4},  // R4 latch byte still open
    {1'b1, 1'b1, 8'h01, 8'h00, 1'b1, 8'h90, 4'd4},  // R4 guard byte locked
    {1'b0, 1'b1, 8'h01, 8'h98, 1'b0, 8'h98, 4'd4},  // R4 pin low unlocks
    {1'b0, 1'b0, 8'h40, 8'h01, 1'b1, 8'h67, 4'd5},  // R5 all protected
    {1'b0, 1'b0, 8'h10, 8'h02, 1'b1, 8'hAA, 4'd5},
    {1'b0, 1'b1, 8'h01, 8'h00, 1'b0, 8'h00, 4'd5},
    {1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 8'h00, 4'd2},  // R2 clear latch
    {1'b0, 1'b0, 8'h40, 8'h02, 1'b1, 8'h67, 4'd3},
    {1'b0, 1'b1, 8'h03, 8'h5A, 1'b1, 8'h00, 4'd3},
    {1'b0, 1'b1, 8'h05, 8'h12, 1'b1, 8'h00, 4'd9},  // R9 unmapped
    {1'b0, 1'b1, 8'hFF, 8'h0F, 1'b0, 8'h0F, 4'd3}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doStart(input logic isReg, input logic [7:0] a, output logic nack);
    @(negedge clk);
    xferStart = 1'b1; xferIsReg = isReg; xferAddr = a;
    #1 nack = ackSuppress;
    @(posedge clk); #1 xferStart = 1'b0;
  endtask

  task automatic doByte(input logic [7:0] d, output logic nack);
    @(negedge clk);
    byteValid = 1'b1; byteData = d;
    #1 nack = ackSuppress;
    @(posedge clk); #1 byteValid = 1'b0;
  endtask

  task automatic doStop(input logic clean);
    @(negedge clk);
    stopStb = 1'b1; stopClean = clean;
    @(posedge clk); #1 stopStb = 1'b0; stopClean = 1'b0;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 4 * BUSY && busy; k++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic readBack(input logic isReg, input logic [7:0] a, output logic [7:0] d);
    rdIsReg = isReg; rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic write1(input logic isReg, input logic [7:0] a, input logic [7:0] d);
    logic n;
    doStart(isReg, a, n);
    doByte(d, n);
    doStop(1'b1);
    waitIdle();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nFail++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic n;
    logic [7:0] d;
    int cnt;
    vec_t v;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 ackSuppress", ackSuppress, 0);
    readBack(1'b1, 8'h00, d); chk("R1 latch byte", d, 8'h00);
    readBack(1'b1, 8'h01, d); chk("R1 guard byte", d, 8'h00);
    readBack(1'b1, 8'hFF, d); chk("R1 fault byte", d, 8'h00);

    for (int i = 0; i < NV; i++) begin
      v = vec_t'(VEC[i]);
      protPin = v.pin;
      doStart(v.isReg, v.addr, n);
      doByte(v.data, n);
      chk($sformatf("R%0d row %0d ack", v.req, i), n, v.nack);
      doStop(1'b1);
      waitIdle();
      readBack(v.isReg, v.addr, d);
      chk($sformatf("R%0d row %0d readback", v.req, i), d, v.rd);
    end
    protPin = 1'b0;

    // R2 latch write starts no busy period
    doStart(1'b1, 8'h00, n); doByte(8'h80, n); doStop(1'b1);
    chk("R2 no busy after latch write", busy, 0);
    readBack(1'b1, 8'h00, d); chk("R2 latch set", d, 8'h80);
    // R3 fault write starts no busy period
    doStart(1'b1, 8'hFF, n); doByte(8'h3C, n); doStop(1'b1);
    chk("R3 no busy after fault write", busy, 0);

    // R6 page wrap: start at 2Eh, 20 bytes of i+1
    doStart(1'b0, 8'h2E, n);
    for (int i = 0; i < 20; i++) doByte(8'(i + 1), n);
    chk("R6 pointer before stop", addrPtr, 8'h22);
    doStop(1'b1);
    chk("R6 pointer after stop", addrPtr, 8'h22);
    waitIdle();
    readBack(1'b0, 8'h2E, d); chk("R6 overwrite 2E", d, 8'h11);
    readBack(1'b0, 8'h21, d); chk("R6 overwrite 21", d, 8'h14);
    readBack(1'b0, 8'h25, d); chk("R6 single 25", d, 8'h08);
    readBack(1'b0, 8'h2D, d); chk("R6 last before wrap", d, 8'h10);

    // R7 torn stop and empty stop
    write1(1'b0, 8'h50, 8'hA5);
    doStart(1'b0, 8'h50, n); doByte(8'h5A, n); doStop(1'b0);
    chk("R7 torn stop no busy", busy, 0);
    readBack(1'b0, 8'h50, d); chk("R7 torn stop discards", d, 8'hA5);
    doStart(1'b0, 8'h50, n); doStop(1'b1);
    chk("R7 empty stop no busy", busy, 0);
    readBack(1'b0, 8'h50, d); chk("R7 empty stop keeps", d, 8'hA5);

    // R8 busy length
    doStart(1'b0, 8'h60, n); doByte(8'h10, n); doStop(1'b1);
    cnt = 0;
    for (int k = 0; k < 4 * BUSY && busy; k++) begin
      cnt++;
      @(posedge clk); #1;
    end
    chk("R8 busy cycles", cnt, BUSY);

    // R8 refusal during busy
    doStart(1'b0, 8'h61, n); doByte(8'h20, n); doStop(1'b1);
    chk("R8 busy after commit", busy, 1);
    doStart(1'b0, 8'h60, n);
    chk("R8 start refused", n, 1);
    doByte(8'h33, n);
    chk("R8 byte refused", n, 1);
    doStop(1'b1);
    waitIdle();
    readBack(1'b0, 8'h60, d); chk("R8 ignored during busy", d, 8'h10);
    readBack(1'b0, 8'h61, d); chk("R8 commit stored", d, 8'h20);
    write1(1'b0, 8'h60, 8'h34);
    readBack(1'b0, 8'h60, d); chk("R8 writes resume", d, 8'h34);

    // R9 extra register bytes
    doStart(1'b1, 8'h03, n);
    doByte(8'h21, n); chk("R9 first byte ack", n, 0);
    doByte(8'h34, n); chk("R9 second byte refused", n, 1);
    doStop(1'b1);
    waitIdle();
    readBack(1'b1, 8'h03, d); chk("R9 first byte kept", d, 8'h21);

    finished = 1;
    summary();
    $finish;
  end
endmodule